// File: doc/BRIEF.md
# XGMII to XAUI Transmit Code-Group Mapper

This block sits between a 10-gigabit MAC's 32-bit XGMII transmit port and four 8B/10B encoders. Every valid column it turns the four byte lanes and their control bits into four code-group selections. Each selection is a control flag plus the byte that names either a data group Dxx.y or a special K group. The encoder that follows turns each selection into a 10-bit symbol.

Data bytes pass through unchanged. Start, terminate, sequence and error characters become their special groups, and any control byte the block does not recognise becomes the error group. Idle characters are never sent as one fixed code. All idle lanes of a column carry one group, picked from a free-running LFSR. An alignment group is inserted at a pseudo-random spacing, and the other idle columns choose between the comma group and the skip group. This gives the receive side the commas and alignment columns it needs to lock and deskew.

The result is registered, so the block has one cycle of latency and forwards a valid flag.

Top module: `xaui_tx_mapper`

## Requirements
- R1: `out_valid` equals the `in_valid` of the previous clock, and each column's result appears on the outputs exactly one cycle after that column is accepted.
- R2: Lane i of the input is `xgmii_d[8i+7:8i]` with control bit `xgmii_c[i]`, and its result is lane i of the output, `cg_val[8i+7:8i]` and `cg_k[i]`. A lane with control bit 0 yields flag 0 and the same byte value (a data group).
- R3: On a lane with control bit 1, byte 0x9C (sequence) yields K28.4 (0x9C), byte 0xFB (start) yields K27.7 (0xFB) and byte 0xFD (terminate) yields K29.7 (0xFD). Each of these has flag 1.
- R4: On a lane with control bit 1, byte 0xFE (error) and every byte other than 0x07, 0x9C, 0xFB, 0xFD and 0xFE yield K30.7 (0xFE) with flag 1.
- R5: On a lane with control bit 1, byte 0x07 (idle) yields flag 1 and one of three groups: K28.0 (0x1C, skip), K28.3 (0x7C, alignment) or K28.5 (0xBC, comma).
- R6: All idle lanes of one column carry the same group, including the idle lanes that follow a terminate in the same column. Over a long idle stream both 0x1C and 0xBC appear.
- R7: Two alignment columns are at least 16 valid columns apart. While every valid column holds at least one idle lane, the next alignment column comes no more than 31 valid columns after the last one. The first column with an idle lane after reset is an alignment column.
- R8: While the synchronous active-high `rst` is high, and after it until the first valid column, `out_valid` is 0 and every output lane is K28.5 (0xBC) with flag 1.
- R9: A cycle with `in_valid` low leaves `cg_k` and `cg_val` unchanged. Such a cycle does not count toward the alignment spacing of R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Column on `xgmii_d`/`xgmii_c` is valid |
| xgmii_d | input | 32 | Four byte lanes, lane 0 in bits 7:0 |
| xgmii_c | input | 4 | Per-lane control flag, bit i for lane i |
| out_valid | output | 1 | Registered valid for the output column |
| cg_k | output | 4 | Per-lane code-group flag: 1 = K group, 0 = data group |
| cg_val | output | 32 | Per-lane code-group byte, lane i in bits 8i+7:8i |

## Verification
The assertions assume that `rst` is high at time zero and that `xgmii_d`/`xgmii_c` are known whenever `in_valid` is high. Beyond that they accept any column: any mix of control and data lanes, any control byte, and any pattern of valid gaps. The spacing checker only counts output columns that carry the alignment byte with the K flag set. The stimulus drives every lane from defined values, and it raises `in_valid` only after reset has been seen. Random columns mix full idle, terminate-then-idle, start, sequence and arbitrary control bytes. Long idle runs let the upper spacing bound and the skip/comma mix both show.

// File: rtl/xaui_map_pkg.sv
package xaui_map_pkg;

  localparam int unsigned BYTE_W = 8;

  // Control bytes seen on the parallel side
  localparam logic [7:0] XG_IDLE  = 8'h07;
  localparam logic [7:0] XG_SEQ   = 8'h9C;
  localparam logic [7:0] XG_START = 8'hFB;
  localparam logic [7:0] XG_TERM  = 8'hFD;
  localparam logic [7:0] XG_ERR   = 8'hFE;

  // Code-group bytes (yyy_xxxxx form) handed to the encoder
  localparam logic [7:0] CG_SKIP  = 8'h1C; // K28.0
  localparam logic [7:0] CG_ALIGN = 8'h7C; // K28.3
  localparam logic [7:0] CG_COMMA = 8'hBC; // K28.5
  localparam logic [7:0] CG_SEQ   = 8'h9C; // K28.4
  localparam logic [7:0] CG_START = 8'hFB; // K27.7
  localparam logic [7:0] CG_TERM  = 8'hFD; // K29.7
  localparam logic [7:0] CG_ERR   = 8'hFE; // K30.7

  typedef struct packed {
    logic       is_k;
    logic [7:0] val;
  } cg_sel_t;

  typedef enum logic [1:0] {
    FILL_COMMA = 2'd0,
    FILL_SKIP  = 2'd1,
    FILL_ALIGN = 2'd2
  } fill_kind_e;

  function automatic logic lane_is_idle(input logic ctl, input logic [7:0] byte_in);
    return ctl && (byte_in == XG_IDLE);
  endfunction

  function automatic logic [7:0] fill_byte(input fill_kind_e kind);
    case (kind)
      FILL_ALIGN: return CG_ALIGN;
      FILL_SKIP:  return CG_SKIP;
      default:    return CG_COMMA;
    endcase
  endfunction

  // One lane: data passes, known controls map, idle takes the column fill
  function automatic cg_sel_t map_lane(input logic ctl, input logic [7:0] byte_in,
                                       input logic [7:0] fill);
    cg_sel_t r;
    if (!ctl) begin
      r.is_k = 1'b0;
      r.val  = byte_in;
    end else begin
      r.is_k = 1'b1;
      case (byte_in)
        XG_IDLE:  r.val = fill;
        XG_SEQ:   r.val = CG_SEQ;
        XG_START: r.val = CG_START;
        XG_TERM:  r.val = CG_TERM;
        default:  r.val = CG_ERR;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/xaui_fill_prng.sv
module xaui_fill_prng #(
  parameter int unsigned        LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]  TAPS      = 'hB400,
  parameter logic [LFSR_W-1:0]  SEED      = 'hACE1,
  parameter int unsigned        SPAN_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  output logic                 pick_bit,
  output logic [SPAN_BITS-1:0] span
);
  logic [LFSR_W-1:0] state;
  logic [LFSR_W-1:0] state_nx;

  // Galois form, shifting right; an all-zero seed is replaced by 1
  always_comb begin
    state_nx = state >> 1;
    if (state[0]) state_nx = state_nx ^ TAPS;
  end

  always_ff @(posedge clk) begin
    if (rst)       state <= (SEED == '0) ? LFSR_W'(1) : SEED;
    else if (step) state <= state_nx;
  end

  assign pick_bit = state[0];
  assign span     = state[SPAN_BITS:1];
endmodule

// File: rtl/xaui_fill_sched.sv
module xaui_fill_sched
  import xaui_map_pkg::*;
#(
  parameter int unsigned MIN_GAP   = 16,
  parameter int unsigned SPAN_BITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 step,
  input  logic                 col_idle,
  input  logic                 pick_bit,
  input  logic [SPAN_BITS-1:0] span,
  output fill_kind_e           kind,
  output logic                 align_due
);
  localparam int unsigned CW = $clog2(MIN_GAP + (1 << SPAN_BITS));

  logic [CW-1:0] wait_cnt;

  assign align_due = (wait_cnt == '0);

  always_comb begin
    if (col_idle && align_due) kind = FILL_ALIGN;
    else if (pick_bit)         kind = FILL_SKIP;
    else                       kind = FILL_COMMA;
  end

  // Counts valid columns left until an alignment column may be sent again
  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
    end else if (step) begin
      if (col_idle && align_due) wait_cnt <= CW'(MIN_GAP - 1) + CW'(span);
      else if (!align_due)       wait_cnt <= wait_cnt - CW'(1);
    end
  end
endmodule

// File: rtl/xaui_lane_map.sv
module xaui_lane_map
  import xaui_map_pkg::*;
(
  input  logic       ctl,
  input  logic [7:0] byte_in,
  input  logic [7:0] fill,
  output logic       is_idle,
  output logic       out_k,
  output logic [7:0] out_val
);
  cg_sel_t sel;

  always_comb begin
    sel     = map_lane(ctl, byte_in, fill);
    is_idle = lane_is_idle(ctl, byte_in);
    out_k   = sel.is_k;
    out_val = sel.val;
  end
endmodule

// File: rtl/xaui_tx_mapper.sv
module xaui_tx_mapper
  import xaui_map_pkg::*;
#(
  parameter int unsigned        LANES     = 4,
  parameter int unsigned        MIN_GAP   = 16,
  parameter int unsigned        SPAN_BITS = 4,
  parameter int unsigned        LFSR_W    = 16,
  parameter logic [LFSR_W-1:0]  TAPS      = 'hB400,
  parameter logic [LFSR_W-1:0]  SEED      = 'hACE1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [LANES*BYTE_W-1:0]   xgmii_d,
  input  logic [LANES-1:0]          xgmii_c,
  output logic                      out_valid,
  output logic [LANES-1:0]          cg_k,
  output logic [LANES*BYTE_W-1:0]   cg_val
);
  localparam int unsigned DW = LANES * BYTE_W;

  logic                 pick_bit;
  logic [SPAN_BITS-1:0] span;
  fill_kind_e           fill_kind;
  logic                 align_due;
  logic [7:0]           idle_val;
  logic [LANES-1:0]     lane_idle;
  logic                 col_has_idle;
  logic [LANES-1:0]     k_nx;
  logic [DW-1:0]        val_nx;

  xaui_fill_prng #(
    .LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED), .SPAN_BITS(SPAN_BITS)
  ) u_prng (
    .clk(clk), .rst(rst), .step(in_valid),
    .pick_bit(pick_bit), .span(span)
  );

  xaui_fill_sched #(
    .MIN_GAP(MIN_GAP), .SPAN_BITS(SPAN_BITS)
  ) u_sched (
    .clk(clk), .rst(rst), .step(in_valid), .col_idle(col_has_idle),
    .pick_bit(pick_bit), .span(span), .kind(fill_kind), .align_due(align_due)
  );

  assign idle_val     = fill_byte(fill_kind);
  assign col_has_idle = |lane_idle;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    xaui_lane_map u_map (
      .ctl     (xgmii_c[g]),
      .byte_in (xgmii_d[g*BYTE_W +: BYTE_W]),
      .fill    (idle_val),
      .is_idle (lane_idle[g]),
      .out_k   (k_nx[g]),
      .out_val (val_nx[g*BYTE_W +: BYTE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      cg_k      <= '1;
      cg_val    <= {LANES{CG_COMMA}};
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        cg_k   <= k_nx;
        cg_val <= val_nx;
      end
    end
  end
endmodule

// File: rtl/xaui_tx_mapper_chk.sv
module xaui_tx_mapper_chk
  import xaui_map_pkg::*;
#(
  parameter int unsigned LANES   = 4,
  parameter int unsigned MIN_GAP = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [LANES*8-1:0]      xgmii_d,
  input logic [LANES-1:0]        xgmii_c,
  input logic                    out_valid,
  input logic [LANES-1:0]        cg_k,
  input logic [LANES*8-1:0]      cg_val,
  input logic [7:0]              idle_val
);
  localparam int unsigned SW = $clog2(MIN_GAP + 1);

  logic          out_align;
  logic [SW-1:0] since_align;

  always_comb begin
    out_align = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (cg_k[i] && cg_val[8*i +: 8] == CG_ALIGN) out_align = 1'b1;
  end

  // Valid output columns since the last alignment column, saturating
  always_ff @(posedge clk) begin
    if (rst)                               since_align <= SW'(MIN_GAP);
    else if (out_valid && out_align)       since_align <= SW'(1);
    else if (out_valid && since_align < SW'(MIN_GAP)) since_align <= since_align + SW'(1);
  end

  a_r1_valid_rise: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
  a_r1_valid_fall: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);

  a_r5_fill_set: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (idle_val == CG_SKIP || idle_val == CG_ALIGN || idle_val == CG_COMMA));

  a_r7_align_gap: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_align) |-> (since_align >= SW'(MIN_GAP)));

  a_r8_reset_out: assert property (@(posedge clk)
    rst |=> (!out_valid && cg_k == '1 && cg_val == {LANES{CG_COMMA}}));

  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(cg_k) && $stable(cg_val)));

  for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
    a_r2_data_pass: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !xgmii_c[g]) |=>
        (!cg_k[g] && cg_val[8*g +: 8] == $past(xgmii_d[8*g +: 8])));

    a_r3_known_ctl: assert property (@(posedge clk) disable iff (rst)
      (in_valid && xgmii_c[g] && (xgmii_d[8*g +: 8] == XG_SEQ || xgmii_d[8*g +: 8] == XG_START ||
                                  xgmii_d[8*g +: 8] == XG_TERM)) |=>
        (cg_k[g] && cg_val[8*g +: 8] == $past(xgmii_d[8*g +: 8])));

    a_r4_err_ctl: assert property (@(posedge clk) disable iff (rst)
      (in_valid && xgmii_c[g] && xgmii_d[8*g +: 8] != XG_IDLE && xgmii_d[8*g +: 8] != XG_SEQ &&
       xgmii_d[8*g +: 8] != XG_START && xgmii_d[8*g +: 8] != XG_TERM) |=>
        (cg_k[g] && cg_val[8*g +: 8] == CG_ERR));

    a_r6_fill_lane: assert property (@(posedge clk) disable iff (rst)
      (in_valid && xgmii_c[g] && xgmii_d[8*g +: 8] == XG_IDLE) |=>
        (cg_k[g] && cg_val[8*g +: 8] == $past(idle_val)));
  end
endmodule

bind xaui_tx_mapper xaui_tx_mapper_chk #(.LANES(LANES), .MIN_GAP(MIN_GAP)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .xgmii_d(xgmii_d), .xgmii_c(xgmii_c),
  .out_valid(out_valid), .cg_k(cg_k), .cg_val(cg_val), .idle_val(idle_val)
);

// File: tb/xaui_tx_mapper_bench.sv
module xaui_tx_mapper_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] xgmii_d = '0;
  logic [3:0]  xgmii_c = '0;
  logic        out_valid;
  logic [3:0]  cg_k;
  logic [31:0] cg_val;

  int n_checks = 0;
  int n_fail   = 0;
  int col_idx  = 0;
  int last_a   = -1;
  bit idle_run = 1'b0;
  bit need_a   = 1'b1;
  bit seen_r   = 1'b0;
  bit seen_k   = 1'b0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  xaui_tx_mapper u_xaui_tx_mapper (
    .clk(clk), .rst(rst), .in_valid(in_valid), .xgmii_d(xgmii_d), .xgmii_c(xgmii_c),
    .out_valid(out_valid), .cg_k(cg_k), .cg_val(cg_val)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // Expected {flag, byte} for a non-idle lane
  function automatic logic [8:0] want_lane(input logic c, input logic [7:0] d);
    if (!c) return {1'b0, d};
    if (d == 8'h9C || d == 8'hFB || d == 8'hFD || d == 8'hFE) return {1'b1, d};
    return {1'b1, 8'hFE};
  endfunction

  function automatic string req_of(input logic c, input logic [7:0] d);
    if (!c) return "R2";
    if (d == 8'h9C || d == 8'hFB || d == 8'hFD) return "R3";
    return "R4";
  endfunction

  task automatic apply_reset();
    rst = 1'b1;
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1;
      xgmii_d  = $urandom;
      xgmii_c  = 4'h0;
      @(posedge clk); @(negedge clk);
      check(!out_valid && cg_k == 4'hF && cg_val == 32'hBCBCBCBC, "R8", "in reset",
            {cg_k, out_valid, cg_val[26:0]}, {4'hF, 1'b0, 27'h4BCBCBC});
    end
    rst = 1'b0;
    in_valid = 1'b0;
    @(posedge clk); @(negedge clk);
    check(!out_valid && cg_k == 4'hF && cg_val == 32'hBCBCBCBC, "R8", "after reset",
          cg_val, 32'hBCBCBCBC);
    last_a = -1; idle_run = 1'b0; need_a = 1'b1;
  endtask

  task automatic run_col(input logic [31:0] d, input logic [3:0] c);
    logic [7:0] fill;
    bit has_idle;
    bit is_a;
    in_valid = 1'b1;
    xgmii_d  = d;
    xgmii_c  = c;
    @(posedge clk); @(negedge clk);
    check(out_valid == 1'b1, "R1", "out_valid", {31'd0, out_valid}, 32'd1);
    has_idle = 1'b0;
    fill = 8'h00;
    for (int i = 0; i < 4; i++) begin
      logic [7:0] db;
      logic [7:0] ob;
      db = d[8*i +: 8];
      ob = cg_val[8*i +: 8];
      if (c[i] && db == 8'h07) begin
        check(cg_k[i] && (ob == 8'h1C || ob == 8'h7C || ob == 8'hBC), "R5", "idle group",
              {23'd0, cg_k[i], ob}, {23'd0, 1'b1, 8'hBC});
        if (!has_idle) fill = ob;
        else check(ob == fill, "R6", "idle lanes differ", {24'd0, ob}, {24'd0, fill});
        has_idle = 1'b1;
      end else begin
        logic [8:0] w;
        w = want_lane(c[i], db);
        check({cg_k[i], ob} == w, req_of(c[i], db), "lane map",
              {23'd0, cg_k[i], ob}, {23'd0, w});
      end
    end
    is_a = has_idle && fill == 8'h7C;
    if (has_idle && fill == 8'h1C) seen_r = 1'b1;
    if (has_idle && fill == 8'hBC) seen_k = 1'b1;
    if (has_idle && need_a)
      check(is_a, "R7", "first idle after reset", {24'd0, fill}, 32'h7C);
    if (is_a && last_a >= 0)
      check(col_idx - last_a >= 16, "R7", "alignment too soon", col_idx - last_a, 32'd16);
    if (has_idle && !is_a && idle_run && last_a >= 0)
      check(col_idx - last_a < 31, "R7", "alignment late", col_idx - last_a, 32'd31);
    if (has_idle) need_a = 1'b0;
    if (!has_idle) idle_run = 1'b0;
    if (is_a) begin
      last_a = col_idx;
      idle_run = 1'b1;
    end
    col_idx++;
  endtask

  task automatic gap_cycle(input logic [31:0] d, input logic [3:0] c);
    logic [3:0]  pk;
    logic [31:0] pv;
    pk = cg_k;
    pv = cg_val;
    in_valid = 1'b0;
    xgmii_d  = d;
    xgmii_c  = c;
    @(posedge clk); @(negedge clk);
    check(!out_valid, "R1", "out_valid low", {31'd0, out_valid}, 32'd0);
    check(cg_k == pk && cg_val == pv, "R9", "hold on gap", cg_val, pv);
  endtask

  task automatic random_col();
    logic [31:0] d;
    logic [3:0]  c;
    int p;
    d = $urandom;
    c = 4'h0;
    case ($urandom % 8)
      0, 1, 2: begin d = 32'h07070707; c = 4'hF; end
      3: c = 4'h0;
      4: begin
        p = $urandom % 4;
        for (int i = 0; i < 4; i++) begin
          if (i == p) begin d[8*i +: 8] = 8'hFD; c[i] = 1'b1; end
          else if (i > p) begin d[8*i +: 8] = 8'h07; c[i] = 1'b1; end
        end
      end
      5: begin d[7:0] = 8'hFB; c = 4'h1; end
      6: begin
        c = 4'($urandom);
        for (int i = 0; i < 4; i++) begin
          case ($urandom % 6)
            0: d[8*i +: 8] = 8'h07;
            1: d[8*i +: 8] = 8'h9C;
            2: d[8*i +: 8] = 8'hFB;
            3: d[8*i +: 8] = 8'hFD;
            4: d[8*i +: 8] = 8'hFE;
            default: d[8*i +: 8] = 8'($urandom);
          endcase
        end
      end
      default: begin d = 32'h0000009C; c = 4'h1; end
    endcase
    if ($urandom % 16 == 0) gap_cycle($urandom, 4'($urandom));
    run_col(d, c);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "WD", "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    apply_reset();
    // R2 lane order
    run_col(32'h33221100, 4'h0);
    // R3 start, sequence
    run_col(32'hAA5501FB, 4'h1);
    run_col(32'h0000009C, 4'h1);
    // R3/R6 terminate in lane 2, idle in lane 3: first idle after reset
    run_col(32'h07FD1234, 4'hC);
    // R4 error and unknown controls
    run_col(32'h5A00FEFE, 4'hB);
    run_col(32'h07FD0007, 4'hF);
    // R9 gap cycle with different input
    gap_cycle(32'hFFFFFFFF, 4'hF);
    run_col(32'hDEADBEEF, 4'h0);
    // Long idle run for R7 and R6
    for (int k = 0; k < 120; k++) begin
      run_col(32'h07070707, 4'hF);
      if (k % 37 == 5) gap_cycle(32'h07070707, 4'hF);
    end
    for (int k = 0; k < 3000; k++) random_col();
    apply_reset();
    for (int k = 0; k < 60; k++) run_col(32'h07070707, 4'hF);
    check(seen_r && seen_k, "R6", "skip and comma both used", {30'd0, seen_r, seen_k}, 32'd3);
    finish_run();
  end
endmodule